// File: doc/BRIEF.md
# Multiplexed bus latch transceiver

The block joins one narrow port (A) to two ports of the same width (B1 and B2). Traffic can flow either way. From B to A, each B port feeds its own storage stage, and a select input picks which stored value reaches A. From A to B, the A input feeds two independent storage stages: one drives B1 and one drives B2. It is used to fold two data streams onto one path, or to split one path into two. Typical uses are address/data multiplexing and interleaving two memory banks.

Each storage stage is open while its enable is high: the output follows the input in the same cycle. While the enable is low, the stage keeps the value it had on the last rising clock edge at which the enable was high. Each port has an active-low drive enable. A three-state pin is modelled as three signals: an input vector, an output vector and a drive-valid flag. While a port is not driving, its output vector reads zero. The synchronous active-low reset models power-up. It clears every stored value, and for as long as it is low no port drives.

Top module: `mbl_bus_mux`

## Requirements
- R1: While a stage enable is high, its output port follows that stage's input combinationally, in the same cycle (le_a1 to b1_out from a_in, le_a2 to b2_out from a_in, le_b1 and le_b2 to a_out through the select).
- R2: While a stage enable is low, that stage's output keeps the input it sampled at the last rising clock edge with the enable high. Later input changes have no effect.
- R3: a_out shows the B1 stage when pick_b1 is 1 and the B2 stage when pick_b1 is 0. Switching pick_b1 while both stages hold swaps the value in the same cycle.
- R4: The A-to-B1 and A-to-B2 stages are independent. Opening one leaves the value held by the other unchanged.
- R5: A drive enable that is 1 (inactive) forces that port's drive-valid flag to 0 and its output vector to zero, whatever the stage enables and the select are.
- R6: b1_en_n and b2_en_n act independently. Neither, either or both B ports may drive at once.
- R7: While rst_n is 0, all three drive-valid flags are 0. A clock edge with rst_n at 0 clears all four stored values to zero.
- R8: Every path carries WIDTH bits unchanged, all bits set included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which stored values are sampled |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | WIDTH | Value arriving on port A |
| a_out | output | WIDTH | Value driven onto port A (zero when not driving) |
| a_oe | output | 1 | Port A drive valid |
| b1_in | input | WIDTH | Value arriving on port B1 |
| b1_out | output | WIDTH | Value driven onto port B1 (zero when not driving) |
| b1_oe | output | 1 | Port B1 drive valid |
| b2_in | input | WIDTH | Value arriving on port B2 |
| b2_out | output | WIDTH | Value driven onto port B2 (zero when not driving) |
| b2_oe | output | 1 | Port B2 drive valid |
| le_b1 | input | 1 | Opens the B1-to-A stage |
| le_b2 | input | 1 | Opens the B2-to-A stage |
| le_a1 | input | 1 | Opens the A-to-B1 stage |
| le_a2 | input | 1 | Opens the A-to-B2 stage |
| pick_b1 | input | 1 | 1 selects the B1 stage onto A, 0 selects the B2 stage |
| a_en_n | input | 1 | Port A drive enable, active low |
| b1_en_n | input | 1 | Port B1 drive enable, active low |
| b2_en_n | input | 1 | Port B2 drive enable, active low |

## Verification
The bench builds the block with the default WIDTH of 12. This is wide enough to use bit patterns that tell all four stages apart at the same time, and also patterns with every bit set. It therefore catches a lane swapped between stages, a dropped bit, or the select wired to the wrong stage. The vector table runs the stages through opening, holding and reopening. The vectors are ordered so that every held value differs from every live input. As a result, a stage that leaks through while closed gives a visible mismatch. The directed reset test then shows that stored values return to zero.

// File: rtl/mbl_pkg.sv
// Shared definitions for the multiplexed bus latch transceiver.
// Assumes: stage and port indices below are the only ones in use.
package mbl_pkg;

    // Storage stages, in the order the top's stage arrays use.
    typedef enum logic [1:0] {
        STG_B1 = 2'd0,
        STG_B2 = 2'd1,
        STG_A1 = 2'd2,
        STG_A2 = 2'd3
    } mbl_stage_e;

    // Driven ports, in the order the top's port arrays use.
    typedef enum logic [1:0] {
        PRT_A  = 2'd0,
        PRT_B1 = 2'd1,
        PRT_B2 = 2'd2
    } mbl_port_e;

    localparam int unsigned MBL_NUM_STAGES = 4;
    localparam int unsigned MBL_NUM_PORTS  = 3;

endpackage

// File: rtl/mbl_hold_stage.sv
// One storage stage: open (combinational pass) while le is high, and
// holding the value sampled at the last clock edge with le high.
// Assumes: le and d are synchronous to clk; reset is synchronous, active low.
module mbl_hold_stage #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] held_q;

    // Capture the input on every edge with the stage open; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (le) begin
            held_q <= d;
        end
    end

    // Open stage passes the live input, closed stage shows the held value.
    always_comb begin
        q = le ? d : held_q;
    end

endmodule

// File: rtl/mbl_select.sv
// Two-way selector placed after the B-side stages, choosing which one feeds A.
// Assumes: sel_first = 1 picks in_first.
module mbl_select #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             sel_first,
    input  logic [WIDTH-1:0] in_first,
    input  logic [WIDTH-1:0] in_second,
    output logic [WIDTH-1:0] out
);

    // Route the chosen stage to the A side.
    always_comb begin
        out = sel_first ? in_first : in_second;
    end

endmodule

// File: rtl/mbl_port_drive.sv
// Drive gate for one modelled three-state port: raises the drive-valid
// flag only when enabled and out of reset, and zeroes the data otherwise.
// Assumes: en_n is active low; rst_n low means power-up, so no drive.
module mbl_port_drive #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             rst_n,
    input  logic             en_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             oe
);

    // Decide whether the port drives and mask the data when it does not.
    always_comb begin
        oe = rst_n & ~en_n;
        q  = oe ? d : '0;
    end

endmodule

// File: rtl/mbl_bus_mux.sv
// Multiplexed bus latch transceiver top. Four storage stages (two per
// direction), a selector after the B-side stages, and three drive gates.
// Assumes: all inputs synchronous to clk; reset synchronous, active low.
module mbl_bus_mux
    import mbl_pkg::*;
#(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b1_in,
    output logic [WIDTH-1:0] b1_out,
    output logic             b1_oe,
    input  logic [WIDTH-1:0] b2_in,
    output logic [WIDTH-1:0] b2_out,
    output logic             b2_oe,
    input  logic             le_b1,
    input  logic             le_b2,
    input  logic             le_a1,
    input  logic             le_a2,
    input  logic             pick_b1,
    input  logic             a_en_n,
    input  logic             b1_en_n,
    input  logic             b2_en_n
);

    localparam int unsigned NS = MBL_NUM_STAGES;
    localparam int unsigned NP = MBL_NUM_PORTS;

    logic [WIDTH-1:0] stg_d   [NS];
    logic [WIDTH-1:0] stg_q   [NS];
    logic             stg_le  [NS];
    logic [WIDTH-1:0] prt_d   [NP];
    logic [WIDTH-1:0] prt_q   [NP];
    logic             prt_oe  [NP];
    logic             prt_en_n[NP];
    logic [WIDTH-1:0] a_sel;

    // Wire stage inputs and enables by stage index.
    always_comb begin
        stg_d[STG_B1]  = b1_in;
        stg_d[STG_B2]  = b2_in;
        stg_d[STG_A1]  = a_in;
        stg_d[STG_A2]  = a_in;
        stg_le[STG_B1] = le_b1;
        stg_le[STG_B2] = le_b2;
        stg_le[STG_A1] = le_a1;
        stg_le[STG_A2] = le_a2;
    end

    for (genvar s = 0; s < NS; s++) begin : g_stage
        mbl_hold_stage #(.WIDTH(WIDTH)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .le    (stg_le[s]),
            .d     (stg_d[s]),
            .q     (stg_q[s])
        );
    end

    mbl_select #(.WIDTH(WIDTH)) u_select (
        .sel_first (pick_b1),
        .in_first  (stg_q[STG_B1]),
        .in_second (stg_q[STG_B2]),
        .out       (a_sel)
    );

    // Wire port data and enables by port index.
    always_comb begin
        prt_d[PRT_A]     = a_sel;
        prt_d[PRT_B1]    = stg_q[STG_A1];
        prt_d[PRT_B2]    = stg_q[STG_A2];
        prt_en_n[PRT_A]  = a_en_n;
        prt_en_n[PRT_B1] = b1_en_n;
        prt_en_n[PRT_B2] = b2_en_n;
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        mbl_port_drive #(.WIDTH(WIDTH)) u_drive (
            .rst_n (rst_n),
            .en_n  (prt_en_n[p]),
            .d     (prt_d[p]),
            .q     (prt_q[p]),
            .oe    (prt_oe[p])
        );
    end

    // Bring the gated port signals out.
    always_comb begin
        a_out  = prt_q[PRT_A];
        a_oe   = prt_oe[PRT_A];
        b1_out = prt_q[PRT_B1];
        b1_oe  = prt_oe[PRT_B1];
        b2_out = prt_q[PRT_B2];
        b2_oe  = prt_oe[PRT_B2];
    end

endmodule

// File: rtl/mbl_bus_mux_chk.sv
// Property checker for mbl_bus_mux, attached through bind below.
// Assumes: observes only top-level ports.
module mbl_bus_mux_chk #(
    parameter int unsigned WIDTH = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b1_in,
    input logic [WIDTH-1:0] b1_out,
    input logic             b1_oe,
    input logic [WIDTH-1:0] b2_out,
    input logic             b2_oe,
    input logic             le_b1,
    input logic             le_a1,
    input logic             le_a2,
    input logic             pick_b1,
    input logic             a_en_n,
    input logic             b1_en_n,
    input logic             b2_en_n
);

    // R7
    rst_no_drive_chk: assert property (@(posedge clk)
        !rst_n |-> (!a_oe && !b1_oe && !b2_oe));

    // R5
    a_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_en_n |-> (!a_oe && a_out == '0));

    // R1
    b1_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le_a1 && !b1_en_n) |-> (b1_oe && b1_out == a_in));

    // R3
    pick_b1_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_b1 && le_b1 && !a_en_n) |-> (a_out == b1_in));

    // R2
    b2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_a2 && $past(!le_a2) && $past(rst_n) && !b2_en_n && $past(!b2_en_n))
        |-> $stable(b2_out));

    // R6
    b_bank_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!b1_en_n && !b2_en_n) |-> (b1_oe && b2_oe));

endmodule

bind mbl_bus_mux mbl_bus_mux_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b1_in   (b1_in),
    .b1_out  (b1_out),
    .b1_oe   (b1_oe),
    .b2_out  (b2_out),
    .b2_oe   (b2_oe),
    .le_b1   (le_b1),
    .le_a1   (le_a1),
    .le_a2   (le_a2),
    .pick_b1 (pick_b1),
    .a_en_n  (a_en_n),
    .b1_en_n (b1_en_n),
    .b2_en_n (b2_en_n)
);

// File: tb/test_mbl_bus_mux.sv
module test_mbl_bus_mux;

    localparam int W  = 12;
    localparam int NV = 14;
    // Row: le{b1,b2,a1,a2} | pick | en_n{a,b1,b2} | a b1 b2 | exp a b1 b2 | exp oe{a,b1,b2}
    localparam logic [82:0] VEC [NV] = '{
        {4'b0000, 1'b1, 3'b111, 12'h123, 12'h456, 12'h789, 12'h000, 12'h000, 12'h000, 3'b000},
        {4'b0000, 1'b1, 3'b000, 12'h123, 12'h456, 12'h789, 12'h000, 12'h000, 12'h000, 3'b111},
        {4'b1111, 1'b1, 3'b000, 12'hA5A, 12'h3C3, 12'hF0F, 12'h3C3, 12'hA5A, 12'hA5A, 3'b111},
        {4'b0000, 1'b1, 3'b000, 12'h111, 12'h222, 12'h333, 12'h3C3, 12'hA5A, 12'hA5A, 3'b111},
        {4'b0000, 1'b0, 3'b000, 12'h111, 12'h222, 12'h333, 12'hF0F, 12'hA5A, 12'hA5A, 3'b111},
        {4'b0010, 1'b0, 3'b000, 12'h0F0, 12'h222, 12'h333, 12'hF0F, 12'h0F0, 12'hA5A, 3'b111},
        {4'b0001, 1'b0, 3'b000, 12'hABC, 12'h222, 12'h333, 12'hF0F, 12'h0F0, 12'hABC, 3'b111},
        {4'b0000, 1'b0, 3'b010, 12'h000, 12'h222, 12'h333, 12'hF0F, 12'h000, 12'hABC, 3'b101},
        {4'b0000, 1'b0, 3'b001, 12'h000, 12'h222, 12'h333, 12'hF0F, 12'h0F0, 12'h000, 3'b110},
        {4'b0000, 1'b0, 3'b011, 12'h000, 12'h222, 12'h333, 12'hF0F, 12'h000, 12'h000, 3'b100},
        {4'b1000, 1'b1, 3'b000, 12'h000, 12'hFFF, 12'h333, 12'hFFF, 12'h0F0, 12'hABC, 3'b111},
        {4'b0100, 1'b1, 3'b000, 12'h000, 12'h000, 12'h001, 12'hFFF, 12'h0F0, 12'hABC, 3'b111},
        {4'b0000, 1'b0, 3'b000, 12'h000, 12'h000, 12'h000, 12'h001, 12'h0F0, 12'hABC, 3'b111},
        {4'b0000, 1'b1, 3'b100, 12'h000, 12'h000, 12'h000, 12'h000, 12'h0F0, 12'hABC, 3'b011}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_oe, b1_oe, b2_oe;
    logic         le_b1 = 1'b0, le_b2 = 1'b0, le_a1 = 1'b0, le_a2 = 1'b0;
    logic         pick_b1 = 1'b0;
    logic         a_en_n = 1'b1, b1_en_n = 1'b1, b2_en_n = 1'b1;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    mbl_bus_mux #(.WIDTH(W)) i_mbl_bus_mux (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
        .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe),
        .le_b1(le_b1), .le_b2(le_b2), .le_a1(le_a1), .le_a2(le_a2),
        .pick_b1(pick_b1), .a_en_n(a_en_n), .b1_en_n(b1_en_n), .b2_en_n(b2_en_n)
    );

    function automatic string tag_of(int i);
        case (i)
            0, 13:    return "R5";
            1:        return "R7";
            2:        return "R1";
            3, 11:    return "R2";
            4, 12:    return "R3";
            5, 6:     return "R4";
            7, 8, 9:  return "R6";
            default:  return "R8";
        endcase
    endfunction

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // Reset state: no port drives while rst_n is low (R7).
        repeat (3) @(posedge clk);
        @(negedge clk);
        a_en_n = 1'b0; b1_en_n = 1'b0; b2_en_n = 1'b0;
        #2;
        check("R7", "oe during reset", {9'd0, a_oe, b1_oe, b2_oe}, '0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk; each row is sampled before the capturing edge.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {le_b1, le_b2, le_a1, le_a2} = VEC[i][82:79];
            pick_b1 = VEC[i][78];
            {a_en_n, b1_en_n, b2_en_n} = VEC[i][77:75];
            a_in  = VEC[i][74:63];
            b1_in = VEC[i][62:51];
            b2_in = VEC[i][50:39];
            #2;
            check(tag_of(i), $sformatf("row %0d a_out", i),  a_out,  VEC[i][38:27]);
            check(tag_of(i), $sformatf("row %0d b1_out", i), b1_out, VEC[i][26:15]);
            check(tag_of(i), $sformatf("row %0d b2_out", i), b2_out, VEC[i][14:3]);
            check(tag_of(i), $sformatf("row %0d oe", i), {9'd0, a_oe, b1_oe, b2_oe},
                  {9'd0, VEC[i][2:0]});
        end

        // Directed: a reset edge clears every held value (R7).
        @(negedge clk);
        le_b1 = 1'b0; le_b2 = 1'b0; le_a1 = 1'b0; le_a2 = 1'b0;
        a_en_n = 1'b0; b1_en_n = 1'b0; b2_en_n = 1'b0;
        a_in = 12'h7E7; b1_in = 12'h7E7; b2_in = 12'h7E7;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        pick_b1 = 1'b1;
        #2;
        check("R7", "b1 stage after reset", a_out, '0);
        check("R7", "a1 stage after reset", b1_out, '0);
        check("R7", "a2 stage after reset", b2_out, '0);
        @(negedge clk);
        pick_b1 = 1'b0;
        #2;
        check("R7", "b2 stage after reset", a_out, '0);
        check("R7", "oe after reset", {9'd0, a_oe, b1_oe, b2_oe}, 12'h007);

        // Directed: closed stage ignores input changes over several edges (R2).
        @(negedge clk);
        le_a1 = 1'b1; a_in = 12'h5A5;
        @(negedge clk);
        le_a1 = 1'b0;
        for (int k = 0; k < 4; k++) begin
            a_in = 12'(k * 12'h111 + 12'h00F);
            @(negedge clk);
        end
        #2;
        check("R2", "b1 held across edges", b1_out, 12'h5A5);

        finish_run();
    end

endmodule